// File: doc/BRIEF.md
# Outstanding Translation Credit Gate with Ordered Retry

This block sits in front of the first translation level. It caps how many translation probes can be in flight below it at once. Each in-flight probe holds one credit. A probe that is granted downstream takes a credit, and a completion that returns gives one back.

Requesters present a per-port valid each cycle and get an answer in the same cycle. The answer is accept while a credit is free and reject once every credit is held. A rejected port is remembered once, however often it is turned away. Each completion that leaves a credit free wakes exactly one remembered port with a one-cycle retry pulse, chosen in the order the ports were turned away. Picking one among several ready requesters is left to logic outside this block.

Top module: `credit_retry_gate`

## Requirements
- R1: The outstanding count starts at zero after reset. It rises by one on each cycle where `issue_grant` is high and falls by one on each cycle where `cpl_valid` is high while the count is non-zero. It never exceeds MAX_OUT.
- R2: In the same cycle, bit i of `req_accept` equals `req_valid[i]` while the count is below MAX_OUT. Bit i of `req_reject` equals `req_valid[i]` while the count equals MAX_OUT. The other output of the pair is 0.
- R3: `issue_grant` is `issue_req` while the count is below MAX_OUT and 0 while the count equals MAX_OUT.
- R4: A rejected port that is already remembered as stalled is not remembered a second time, so it receives only one retry.
- R5: A completion that leaves a credit free while at least one port is stalled raises exactly one bit of `retry`, for the oldest stalled port, for one cycle, in the cycle after the completion.
- R6: Retries follow the order in which ports were rejected. Ports rejected in the same cycle are ordered lowest index first.
- R7: A port that is rejected again after using its retry joins the back of the stalled order, behind the ports still waiting.
- R8: Reset clears the stalled record, and `retry` is all zeros until a completion occurs.
- R9: A completion while the count is zero has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_PORTS | Per-port request present this cycle |
| req_accept | output | N_PORTS | Request taken, a credit was free |
| req_reject | output | N_PORTS | Request turned away, all credits held |
| retry | output | N_PORTS | One-cycle wake-up to the oldest stalled port |
| issue_req | input | 1 | A probe wants to go downstream |
| issue_grant | output | 1 | Probe may go; takes a credit |
| cpl_valid | input | 1 | A translation returned; frees a credit |

## Verification
A count that drifts by one shows up at the request ports on the next attempt made at the boundary. Either a request is accepted where a reject is due, or a grant is refused, and in both cases this appears in the same cycle the request or probe is presented. A corrupted stalled record shows up one cycle after the next completion. It appears as a missing retry, a retry to the wrong port, a duplicated retry, or a retry out of rejection order. The scenarios therefore fill the credits, reject ports in overlapping patterns, and drain the credits one completion at a time.

// File: rtl/crg_pkg.sv
package crg_pkg;
    localparam int unsigned DEF_PORTS = 4;
    localparam int unsigned DEF_MAX   = 2;

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned depth);
        return (v + 1 >= depth) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/crg_credit_counter.sv
module crg_credit_counter #(
    parameter int unsigned MAX_OUT = crg_pkg::DEF_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_req,
    input  logic cpl_valid,
    output logic full,
    output logic issue_grant,
    output logic dec_fire,
    output logic free_next
);
    localparam int unsigned CW = $clog2(MAX_OUT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    assign full        = (s_q.cnt == CW'(MAX_OUT));
    assign issue_grant = issue_req && !full;
    assign dec_fire    = cpl_valid && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (issue_grant && !dec_fire)      s_d.cnt = s_q.cnt + 1'b1;
        else if (!issue_grant && dec_fire) s_d.cnt = s_q.cnt - 1'b1;
    end

    assign free_next = (s_d.cnt < CW'(MAX_OUT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(MAX_OUT));
    p_no_grant_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !issue_grant);
endmodule

// File: rtl/crg_stall_queue.sv
module crg_stall_queue #(
    parameter int unsigned N_PORTS = crg_pkg::DEF_PORTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] refuse,
    input  logic               pop_en,
    output logic               head_valid,
    output logic [N_PORTS-1:0] retry
);
    localparam int unsigned IDW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam int unsigned OW  = $clog2(N_PORTS + 1);

    typedef struct packed {
        logic [N_PORTS-1:0][IDW-1:0] slot;
        logic [IDW-1:0]              rd;
        logic [IDW-1:0]              wr;
        logic [OW-1:0]               occ;
        logic [N_PORTS-1:0]          member;
        logic [N_PORTS-1:0]          retry;
    } q_state_t;

    q_state_t s_d, s_q;

    assign head_valid = (s_q.occ != '0);
    assign retry      = s_q.retry;

    always_comb begin
        s_d       = s_q;
        s_d.retry = '0;
        if (pop_en && head_valid) begin
            s_d.retry[s_q.slot[s_q.rd]]  = 1'b1;
            s_d.member[s_q.slot[s_q.rd]] = 1'b0;
            s_d.rd  = IDW'(crg_pkg::wrap_inc(int'(s_q.rd), N_PORTS));
            s_d.occ = s_d.occ - 1'b1;
        end
        for (int i = 0; i < N_PORTS; i++) begin
            if (refuse[i] && !s_d.member[i]) begin
                s_d.slot[s_d.wr] = IDW'(i);
                s_d.member[i]    = 1'b1;
                s_d.wr  = IDW'(crg_pkg::wrap_inc(int'(s_d.wr), N_PORTS));
                s_d.occ = s_d.occ + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_retry_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.retry));
    p_member_occ_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.member) == int'(s_q.occ));
endmodule

// File: rtl/credit_retry_gate.sv
module credit_retry_gate #(
    parameter int unsigned N_PORTS = crg_pkg::DEF_PORTS,
    parameter int unsigned MAX_OUT = crg_pkg::DEF_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req_valid,
    output logic [N_PORTS-1:0] req_accept,
    output logic [N_PORTS-1:0] req_reject,
    output logic [N_PORTS-1:0] retry,
    input  logic               issue_req,
    output logic               issue_grant,
    input  logic               cpl_valid
);
    logic full, dec_fire, free_next, head_valid, pop_en;

    crg_credit_counter #(.MAX_OUT(MAX_OUT)) i_cnt (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .cpl_valid(cpl_valid),
        .full(full), .issue_grant(issue_grant), .dec_fire(dec_fire),
        .free_next(free_next)
    );

    assign req_accept = full ? '0 : req_valid;
    assign req_reject = full ? req_valid : '0;
    assign pop_en     = dec_fire && free_next && head_valid;

    crg_stall_queue #(.N_PORTS(N_PORTS)) i_q (
        .clk(clk), .rst_n(rst_n), .refuse(req_reject), .pop_en(pop_en),
        .head_valid(head_valid), .retry(retry)
    );

    p_retry_after_cpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|retry) |-> $past(cpl_valid));
    p_reject_blocks_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_reject) |-> !issue_grant);
    p_accept_reject_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept & req_reject) == '0);
endmodule

// File: tb/test_credit_retry_gate.sv
module test_credit_retry_gate;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] req_valid = '0;
    logic [NP-1:0] req_accept, req_reject, retry;
    logic          issue_req = 1'b0, issue_grant, cpl_valid = 1'b0;

    int total = 0, bad = 0;
    logic [NP-1:0] exp_q[$];
    string         tag_q[$];
    bit            done = 1'b0;

    always #10 clk = ~clk;

    credit_retry_gate #(.N_PORTS(NP), .MAX_OUT(2)) i_credit_retry_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_accept(req_accept),
        .req_reject(req_reject), .retry(retry), .issue_req(issue_req),
        .issue_grant(issue_grant), .cpl_valid(cpl_valid)
    );

    task automatic chk(input string tag, input string what, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check combinational answers,
    // and queue the retry expected after the coming rising edge
    task automatic step(input logic [NP-1:0] rv, input logic iss, input logic cpl,
                        input logic [NP-1:0] e_acc, input logic [NP-1:0] e_rej,
                        input logic e_gnt, input logic [NP-1:0] e_retry, input string tag);
        @(negedge clk);
        req_valid = rv; issue_req = iss; cpl_valid = cpl;
        #1;
        chk(tag, "accept", req_accept, e_acc);
        chk(tag, "reject", req_reject, e_rej);
        chk(tag, "grant", {{(NP-1){1'b0}}, issue_grant}, {{(NP-1){1'b0}}, e_gnt});
        exp_q.push_back(e_retry);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) chk(tag_q.pop_front(), "retry", retry, exp_q.pop_front());
        end
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "retry at reset", retry, '0);
        rst_n = 1'b1;
        step(4'b0000, 0, 0, 4'b0000, 4'b0000, 0, 4'b0000, "R8");
        step(4'b0001, 1, 0, 4'b0001, 4'b0000, 1, 4'b0000, "R2");   // count 1
        step(4'b0000, 1, 0, 4'b0000, 4'b0000, 1, 4'b0000, "R1");   // count 2
        step(4'b1010, 1, 0, 4'b0000, 4'b1010, 0, 4'b0000, "R3");   // stall 1,3
        step(4'b0010, 0, 0, 4'b0000, 4'b0010, 0, 4'b0000, "R4");   // dup ignored
        step(4'b0000, 0, 1, 4'b0000, 4'b0000, 0, 4'b0010, "R5");   // count 1, retry 1
        step(4'b0010, 1, 0, 4'b0010, 4'b0000, 1, 4'b0000, "R1");   // count 2
        step(4'b0010, 0, 0, 4'b0000, 4'b0010, 0, 4'b0000, "R7");   // 1 to tail
        step(4'b0000, 0, 1, 4'b0000, 4'b0000, 0, 4'b1000, "R6");   // retry 3
        step(4'b0000, 0, 1, 4'b0000, 4'b0000, 0, 4'b0010, "R7");   // count 0, retry 1
        step(4'b0000, 0, 1, 4'b0000, 4'b0000, 0, 4'b0000, "R9");   // ignored at zero
        step(4'b0000, 1, 0, 4'b0000, 4'b0000, 1, 4'b0000, "R9");   // count 1
        step(4'b0000, 1, 0, 4'b0000, 4'b0000, 1, 4'b0000, "R9");   // count 2
        step(4'b0001, 0, 0, 4'b0000, 4'b0001, 0, 4'b0000, "R9");   // full confirms no underflow
        step(4'b0000, 1, 1, 4'b0000, 4'b0000, 0, 4'b0001, "R3");   // grant blocked, retry 0
        step(4'b0100, 1, 0, 4'b0100, 4'b0000, 1, 4'b0000, "R1");   // count 1 -> 2
        step(4'b0100, 0, 0, 4'b0000, 4'b0100, 0, 4'b0000, "R2");
        step(4'b0000, 0, 0, 4'b0000, 4'b0000, 0, 4'b0000, "R5");   // no cpl, no retry
        @(negedge clk);
        req_valid = '0; issue_req = 1'b0; cpl_valid = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule